// File: doc/BRIEF.md
# Phase-Shifted Rectified-Sine PWM Generator

This block drives the single power switch of a boost-type power-factor-correcting rectifier without any current loop. The gate pattern follows a fixed rectified-sine law. Its only free parameter is a phase offset. Shifting that offset relative to the input-voltage zero crossing sets the amplitude of the drawn line current. An outer voltage regulator, outside this block, supplies the phase command. It also supplies a gain equal to the ratio of input peak voltage to output voltage.

A one-clock pulse marks each zero crossing of the sensed input voltage and restarts a position counter. That counter steps through one half line cycle. If pulses stop arriving, it keeps running at its nominal rate.

At the end of every carrier period, the block latches a new control value. It forms the shifted angle, takes a parabolic approximation of the sine magnitude at that angle, scales the result by the gain and clamps it to the carrier peak. The gate is then formed by comparing a symmetric triangular carrier against that control value. The average duty is therefore one minus the scaled sine magnitude. This means the duty reaches 100% at the shifted zero crossing.

Top module: `rsine_phase_pwm`

## Requirements
- R1: While reset is asserted, and for the whole first carrier period after it, `gate_o` is low and `duty_o` is 0.
- R2: The carrier counts up from 0 to FULL−1 and back down to 0, with each value held one clock, where FULL = 2^AMP_W. One period is therefore 2·FULL clocks. The gate is high on exactly 2·`duty_o` clocks of each period.
- R3: At each period end, with shifted angle a, the block computes S = floor(4·a·(N−a)·FULL / N²), where N = POS_STEPS. It then computes C = min(FULL, floor(`gain_i`·S / 2^GAIN_FRAC)). For the following period, `duty_o` = FULL − C.
- R4: The shifted angle is a = (position − `phase_i`) mod N. Here `phase_i` is in 0..N−1 and is counted in steps of π/N radians.
- R5: A high `sync_i` sampled at a clock edge sets the position to 0. The position then advances by one every STEP_DIV clocks and wraps from N−1 to 0 whether or not further sync pulses arrive.
- R6: `phase_i` and `gain_i` are sampled only at the last count of a carrier period. Changes at other times leave `gate_o` and `duty_o` unchanged until the next period starts.
- R7: When the scaled product exceeds FULL, the control value saturates. `duty_o` is then 0 and the gate stays low for the whole period.
- R8: With `gain_i` = 0, or at shifted angle 0, `duty_o` = FULL and the gate stays high for the whole period.
- R9: When the position is smaller than `phase_i`, the angle wraps to position + N − `phase_i`. The pattern therefore continues smoothly across a zero crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | One-clock pulse at each input-voltage zero crossing |
| phase_i | input | $clog2(POS_STEPS) | Commanded phase offset, in position steps |
| gain_i | input | GAIN_W | Input-peak / output-voltage ratio, GAIN_FRAC fraction bits |
| gate_o | output | 1 | Switch gate drive |
| duty_o | output | AMP_W+1 | Duty of the current carrier period, in units of 1/FULL |

## Verification
The bench builds the block with POS_STEPS = 200, STEP_DIV = 3, AMP_W = 6, GAIN_W = 10 and GAIN_FRAC = 6. One half line cycle is then 600 clocks and a carrier period is 128 clocks. At that scale, many zero crossings, position wraps without sync and phase wraps fit into a short run. Every carrier period is still checked exactly, both for its duty value and for its gate-high count. The gain range reaches 16×, so saturation at zero duty occurs alongside the unity-gain and zero-gain cases.

// File: rtl/rsine_phase_pwm.sv
module rsine_phase_pwm #(
  parameter int POS_STEPS = 12500,
  parameter int STEP_DIV  = 82,
  parameter int AMP_W     = 11,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sync_i,
  input  logic [$clog2(POS_STEPS)-1:0] phase_i,
  input  logic [GAIN_W-1:0]            gain_i,
  output logic                         gate_o,
  output logic [AMP_W:0]               duty_o
);
  localparam int     PW   = $clog2(POS_STEPS);
  localparam int     DW   = $clog2(STEP_DIV + 1);
  localparam int     FULL = 1 << AMP_W;
  localparam longint NSQ  = longint'(POS_STEPS) * longint'(POS_STEPS);

  logic [AMP_W:0]   cnt;
  logic [DW-1:0]    div;
  logic [PW-1:0]    pos;
  logic [AMP_W:0]   ctrl_q;
  logic [AMP_W:0]   ctrl_nx;
  logic [PW:0]      diff;
  logic [PW:0]      ang;
  logic [63:0]      prod;
  logic [63:0]      smag;
  logic [63:0]      scaled;

  wire               valley = &cnt;
  wire [AMP_W-1:0]   car    = cnt[AMP_W] ? ~cnt[AMP_W-1:0] : cnt[AMP_W-1:0];

  assign diff = {1'b0, pos} + (PW+1)'(POS_STEPS) - {1'b0, phase_i};
  assign ang  = (diff >= (PW+1)'(POS_STEPS)) ? diff - (PW+1)'(POS_STEPS) : diff;

  always_comb begin
    prod    = 64'd4 * 64'(ang) * (64'(POS_STEPS) - 64'(ang));
    smag    = (prod << AMP_W) / 64'(NSQ);
    scaled  = (smag * 64'(gain_i)) >> GAIN_FRAC;
    ctrl_nx = (scaled > 64'(FULL)) ? (AMP_W+1)'(FULL) : scaled[AMP_W:0];
  end

  assign gate_o = {1'b0, car} >= ctrl_q;
  assign duty_o = (AMP_W+1)'(FULL) - ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      div    <= '0;
      pos    <= '0;
      ctrl_q <= (AMP_W+1)'(FULL);
    end else begin
      cnt <= cnt + 1'b1;
      if (valley) ctrl_q <= ctrl_nx;
      if (sync_i) begin
        div <= '0;
        pos <= '0;
      end else if (div == DW'(STEP_DIV - 1)) begin
        div <= '0;
        pos <= (pos == PW'(POS_STEPS - 1)) ? '0 : pos + 1'b1;
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  // R6
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valley |=> $stable(duty_o));

  // R5
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (pos == '0));

  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pos} < (PW+1)'(POS_STEPS));

  // R8
  full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_o == (AMP_W+1)'(FULL)) |-> gate_o);

  // R7
  full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_o == '0) |-> !gate_o);

  // R2
  carrier_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valley |=> (cnt == '0));
endmodule

// File: tb/tb_rsine_phase_pwm.sv
module tb_rsine_phase_pwm;
  localparam int N    = 200;
  localparam int D    = 3;
  localparam int AW   = 6;
  localparam int GW   = 10;
  localparam int GF   = 6;
  localparam int FULL = 1 << AW;
  localparam int P    = 2 * FULL;
  localparam int PW   = $clog2(N);

  logic          clk = 0;
  logic          rst_n = 0;
  logic          sync_i = 0;
  logic [PW-1:0] phase_i = '0;
  logic [GW-1:0] gain_i = '0;
  logic          gate_o;
  logic [AW:0]   duty_o;

  always #2 clk = ~clk;

  rsine_phase_pwm #(.POS_STEPS(N), .STEP_DIV(D), .AMP_W(AW), .GAIN_W(GW), .GAIN_FRAC(GF)) dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .phase_i(phase_i),
    .gain_i(gain_i), .gate_o(gate_o), .duty_o(duty_o));

  int    checks = 0, fails = 0;
  int    e = 0, mpos = 0, mdiv = 0, cur = 0, hi = 0;
  bit    done = 0;
  string tag = "R1";

  function automatic int exp_duty(int p, int th, int g);
    longint a, s, c;
    a = longint'((p - th + N) % N);
    s = (4 * a * (N - a) * FULL) / (longint'(N) * N);
    c = (longint'(g) * s) >>> GF;
    if (c > FULL) c = FULL;
    return FULL - int'(c);
  endfunction

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic tick();
    int pp, th, g;
    bit sy;
    pp = mpos; th = int'(phase_i); g = int'(gain_i); sy = sync_i;
    @(posedge clk);
    e++;
    if (sy) begin
      mpos = 0; mdiv = 0;
    end else if (mdiv == D - 1) begin
      mdiv = 0;
      mpos = (mpos == N - 1) ? 0 : mpos + 1;
    end else begin
      mdiv++;
    end
    if (e % P == 0) begin
      chk(hi == 2 * cur, "R2 gate-high count", hi, 2 * cur);
      cur = exp_duty(pp, th, g);
      hi = 0;
    end
    @(negedge clk);
    if (e % P == 0) chk(int'(duty_o) == cur, "R3 duty value", int'(duty_o), cur);
    if (gate_o) hi++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_sync();
    sync_i = 1;
    tick();
    sync_i = 0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", e, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(gate_o == 0, "R1 gate in reset", int'(gate_o), 0);
    chk(duty_o == 0, "R1 duty in reset", int'(duty_o), 0);
    rst_n = 1;
    if (gate_o) hi++;
    phase_i = PW'(20);
    gain_i  = GW'(64);
    run(P);

    tag = "R8";
    gain_i = '0;
    run(2 * P);
    gain_i = GW'(64);
    phase_i = '0;
    pulse_sync();
    run(3);

    tag = "R7";
    phase_i = PW'(10);
    gain_i  = GW'(1023);
    run(3 * P);

    tag = "R5";
    phase_i = PW'(15);
    gain_i  = GW'(64);
    pulse_sync();
    run(N * D + 3 * P);

    tag = "R9";
    phase_i = PW'(150);
    gain_i  = GW'(80);
    pulse_sync();
    run(4 * P);

    tag = "R4";
    phase_i = PW'(N - 1);
    run(2 * P);

    tag = "R6";
    for (int i = 0; i < 4 * P; i++) begin
      if (i % 7 == 3) begin
        phase_i = PW'($urandom_range(N - 1, 0));
        gain_i  = GW'($urandom_range(255, 0));
      end
      tick();
    end

    tag = "R3";
    for (int k = 0; k < 200; k++) begin
      phase_i = PW'($urandom_range(N - 1, 0));
      if ($urandom_range(3, 0) == 0) gain_i = GW'($urandom_range(1023, 0));
      else                           gain_i = GW'($urandom_range(160, 0));
      if ($urandom_range(2, 0) == 0) pulse_sync();
      run(int'($urandom_range(400, 50)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule